// File: doc/BRIEF.md
# Fail-Safe Clock Monitor with Two-Speed Start-Up

The block supervises a primary system clock with a slow sample clock taken from the always-running internal oscillator. Every sample period it sends a request token into the primary clock domain and expects the token back before the middle of that period. If the token has not returned, the primary clock is treated as dead. The block then raises a sticky interrupt flag and a failure output, and it moves the system clock back to the internal oscillator through a glitch-free switch.

Arming depends on the oscillator mode strap. With an external clock or an RC oscillator, the primary clock is selected and monitored straight after reset or wake-up. With a crystal mode, the system runs from the internal oscillator while a start-up timer counts primary cycles. The monitor stays disarmed during that time, so a slow crystal start is never reported as a failure. When the timer expires the block switches to the primary clock, and a status output goes high once the switch has completed.

Top module: `fail_safe_clk_mon`

## Requirements
- R1: While `rst_ni` is low, `clk_sel_o`, `osts_o`, `osc_fail_if_o` and `cm_fail_o` are all 0.
- R2: In a crystal mode (`mode_i` 2 = LP, 3 = XT, 4 = HS, 5..7 treated as crystal), `clk_sel_o` and `osts_o` stay 0 until OST_CYCLES (1024) primary rising edges have occurred after reset release or wake. After that, both are 1 within 40 internal-clock cycles.
- R3: While `clk_sel_o` is 0 during start-up, `osc_fail_if_o` never rises, even when the primary clock does not toggle at all.
- R4: In mode 0 (external clock) or mode 1 (RC), the start-up timer is skipped: `clk_sel_o` and `osts_o` are 1 within 24 internal-clock cycles after reset release.
- R5: If the primary clock stops while `clk_sel_o` is 1, `osc_fail_if_o` and `cm_fail_o` go to 1 within 2·2^SAMPLE_DIV_W (64) internal-clock cycles.
- R6: A primary clock with a half period of at most 11 ns never raises `osc_fail_if_o`.
- R7: After a failure, `clk_sel_o` and `osts_o` are 0 and `cm_fail_o` stays 1 until the next sleep or reset.
- R8: `osc_fail_if_o` stays 1 until a `fail_clr_i` pulse, which clears it one cycle later. The clear leaves `cm_fail_o` unchanged.
- R9: Raising `sleep_i` clears `osts_o`, `clk_sel_o` and `cm_fail_o`. On wake, start-up restarts by mode, including a new full timer run in crystal modes.
- R10: After a failure with the primary clock stopped, `sys_clk_o` keeps toggling at the internal-clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_clk_i | input | 1 | Internal oscillator clock; also the sample-clock source |
| pri_clk_i | input | 1 | Primary oscillator clock under supervision |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Oscillator mode strap (0 ext, 1 RC, 2 LP, 3 XT, 4+ HS) |
| sleep_i | input | 1 | High while the device sleeps; falling edge is wake-up |
| fail_clr_i | input | 1 | Software clear of the failure interrupt flag |
| sys_clk_o | output | 1 | Glitch-free muxed system clock |
| clk_sel_o | output | 1 | 1 = primary clock requested as system clock |
| osts_o | output | 1 | Start-up and switch-over complete |
| osc_fail_if_o | output | 1 | Sticky oscillator-fail interrupt flag |
| cm_fail_o | output | 1 | Clock-monitor failure state |

## Verification
A corrupted controller state shows at once at the ports. Examples are `osts_o` high without `clk_sel_o`, or a flag that rises during crystal start-up, and these appear within one internal-clock cycle. A broken token loop in the detector shows either as a spurious flag within one sample period on a healthy clock, or as a missing flag more than 64 cycles after the primary clock stops. A wrong start-up counter shows as a switch that comes early or late compared with the primary edge count the bench keeps itself. A broken clock switch shows as `sys_clk_o` going silent after a failure.

// File: rtl/fscm_pkg.sv
`timescale 1ns/1ps
package fscm_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP  = 3'd0,
    ST_OST    = 3'd1,
    ST_SWITCH = 3'd2,
    ST_RUN    = 3'd3,
    ST_FAIL   = 3'd4
  } fscm_state_e;

  localparam logic [2:0] MODE_EXT = 3'd0;
  localparam logic [2:0] MODE_RC  = 3'd1;

  function automatic logic mode_is_crystal(input logic [2:0] mode);
    return (mode != MODE_EXT) && (mode != MODE_RC);
  endfunction

endpackage

// File: rtl/fscm_sync.sv
`timescale 1ns/1ps
module fscm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= RST_VAL;
        else         stage_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= {STAGES{RST_VAL}};
        else         stage_q <= {stage_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fscm_pri_side.sv
`timescale 1ns/1ps
module fscm_pri_side #(
  parameter int OST_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic pri_clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  input  logic req_i,
  output logic ost_done_o,
  output logic ack_o
);
  localparam int CNT_W = $clog2(OST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OST_CYCLES - 1);

  logic             ost_rst_raw_n;
  logic             ost_rst_n;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  // timer restarts on reset and while asleep; release is synchronous to primary clock
  assign ost_rst_raw_n = rst_ni & ~sleep_i;

  fscm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_ost_rst_sync (
    .clk_i (pri_clk_i),
    .rst_ni(ost_rst_raw_n),
    .d_i   (1'b1),
    .q_o   (ost_rst_n)
  );

  always_ff @(posedge pri_clk_i or negedge ost_rst_n) begin
    if (!ost_rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == CNT_LAST) done_q <= 1'b1;
      else                   cnt_q  <= cnt_q + 1'b1;
    end
  end

  // token echo: primary clock must run for the request to come back
  fscm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_req_sync (
    .clk_i (pri_clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (ack_o)
  );

  assign ost_done_o = done_q;
endmodule

// File: rtl/fscm_detector.sv
`timescale 1ns/1ps
module fscm_detector #(
  parameter int DIV_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic ack_i,
  output logic req_o,
  output logic fail_o
);
  localparam logic [DIV_W-1:0] PH_TEST = {1'b1, {(DIV_W-1){1'b0}}};

  logic [DIV_W-1:0] phase_q;
  logic             req_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      req_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      phase_q <= phase_q + 1'b1;
      if (!arm_i) begin
        valid_q <= 1'b0;
      end else if (phase_q == '0) begin
        req_q   <= ~req_q;
        valid_q <= 1'b1;
      end
    end
  end

  // test point half a sample period after the token was launched
  assign fail_o = arm_i && valid_q && (phase_q == PH_TEST) && (req_q != ack_i);
  assign req_o  = req_q;
endmodule

// File: rtl/fscm_clk_mux.sv
`timescale 1ns/1ps
module fscm_clk_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic pri_clk_i,
  input  logic int_clk_i,
  input  logic rst_ni,
  input  logic sel_pri_i,
  input  logic force_int_i,
  output logic clk_o,
  output logic pri_on_o
);
  logic pri_rst_n;
  logic en_p_pre_q, en_p_q;
  logic en_i_pre_q, en_i_q;
  logic en_i_in_pri, en_p_in_int;

  // a dead primary clock cannot drop its own enable, so failure clears it asynchronously
  assign pri_rst_n = rst_ni & ~force_int_i;

  fscm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_eni_sync (
    .clk_i (pri_clk_i),
    .rst_ni(pri_rst_n),
    .d_i   (en_i_q),
    .q_o   (en_i_in_pri)
  );

  always_ff @(posedge pri_clk_i or negedge pri_rst_n) begin
    if (!pri_rst_n) en_p_pre_q <= 1'b0;
    else            en_p_pre_q <= sel_pri_i & ~en_i_in_pri;
  end

  always_ff @(negedge pri_clk_i or negedge pri_rst_n) begin
    if (!pri_rst_n) en_p_q <= 1'b0;
    else            en_p_q <= en_p_pre_q;
  end

  fscm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_enp_sync (
    .clk_i (int_clk_i),
    .rst_ni(rst_ni),
    .d_i   (en_p_q),
    .q_o   (en_p_in_int)
  );

  always_ff @(posedge int_clk_i or negedge rst_ni) begin
    if (!rst_ni) en_i_pre_q <= 1'b1;
    else         en_i_pre_q <= ~sel_pri_i & ~en_p_in_int;
  end

  always_ff @(negedge int_clk_i or negedge rst_ni) begin
    if (!rst_ni) en_i_q <= 1'b1;
    else         en_i_q <= en_i_pre_q;
  end

  assign clk_o    = (pri_clk_i & en_p_q) | (int_clk_i & en_i_q);
  assign pri_on_o = en_p_in_int;
endmodule

// File: rtl/fail_safe_clk_mon.sv
`timescale 1ns/1ps
module fail_safe_clk_mon
  import fscm_pkg::*;
#(
  parameter int OST_CYCLES   = 1024,
  parameter int SAMPLE_DIV_W = 5,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       int_clk_i,
  input  logic       pri_clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  input  logic       sleep_i,
  input  logic       fail_clr_i,
  output logic       sys_clk_o,
  output logic       clk_sel_o,
  output logic       osts_o,
  output logic       osc_fail_if_o,
  output logic       cm_fail_o
);
  fscm_state_e state_q, state_d;
  logic sleep_s, ost_done_raw, ost_done_s;
  logic req, ack_raw, ack_s;
  logic det_fail, pri_on_s;
  logic armed, force_int, crystal;
  logic flag_q;

  assign crystal = mode_is_crystal(mode_i);

  fscm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sleep_sync (
    .clk_i(int_clk_i), .rst_ni(rst_ni), .d_i(sleep_i), .q_o(sleep_s)
  );

  fscm_pri_side #(.OST_CYCLES(OST_CYCLES), .SYNC_STAGES(SYNC_STAGES)) i_pri_side (
    .pri_clk_i (pri_clk_i),
    .rst_ni    (rst_ni),
    .sleep_i   (sleep_i),
    .req_i     (req),
    .ost_done_o(ost_done_raw),
    .ack_o     (ack_raw)
  );

  fscm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_done_sync (
    .clk_i(int_clk_i), .rst_ni(rst_ni), .d_i(ost_done_raw), .q_o(ost_done_s)
  );

  fscm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_ack_sync (
    .clk_i(int_clk_i), .rst_ni(rst_ni), .d_i(ack_raw), .q_o(ack_s)
  );

  fscm_detector #(.DIV_W(SAMPLE_DIV_W)) i_detector (
    .clk_i (int_clk_i),
    .rst_ni(rst_ni),
    .arm_i (armed),
    .ack_i (ack_s),
    .req_o (req),
    .fail_o(det_fail)
  );

  fscm_clk_mux #(.SYNC_STAGES(SYNC_STAGES)) i_clk_mux (
    .pri_clk_i  (pri_clk_i),
    .int_clk_i  (int_clk_i),
    .rst_ni     (rst_ni),
    .sel_pri_i  (armed),
    .force_int_i(force_int),
    .clk_o      (sys_clk_o),
    .pri_on_o   (pri_on_s)
  );

  always_comb begin
    state_d = state_q;
    if (sleep_s) begin
      state_d = ST_SLEEP;
    end else begin
      unique case (state_q)
        ST_SLEEP:  state_d = crystal ? ST_OST : ST_SWITCH;
        ST_OST:    if (!crystal || ost_done_s) state_d = ST_SWITCH;
        ST_SWITCH: if (det_fail) state_d = ST_FAIL;
                   else if (pri_on_s) state_d = ST_RUN;
        ST_RUN:    if (det_fail) state_d = ST_FAIL;
        ST_FAIL:   state_d = ST_FAIL;
        default:   state_d = ST_SLEEP;
      endcase
    end
  end

  always_ff @(posedge int_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OST;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= det_fail | (flag_q & ~fail_clr_i);
    end
  end

  assign armed         = (state_q == ST_SWITCH) || (state_q == ST_RUN);
  assign force_int     = (state_q == ST_FAIL) || (state_q == ST_SLEEP);
  assign clk_sel_o     = armed;
  assign osts_o        = (state_q == ST_RUN);
  assign cm_fail_o     = (state_q == ST_FAIL);
  assign osc_fail_if_o = flag_q;
endmodule

// File: rtl/fscm_checker.sv
`timescale 1ns/1ps
module fscm_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic fail_clr_i,
  input logic clk_sel_o,
  input logic osts_o,
  input logic osc_fail_if_o,
  input logic cm_fail_o
);
  // R3: a failure can only be declared while the primary clock is selected
  a_r3_flag_only_when_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_fail_if_o) |-> $past(clk_sel_o));

  // R2: start-up status implies the primary clock is selected
  a_r2_status_needs_primary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osts_o |-> clk_sel_o);

  // R7: failure state keeps the system on the internal clock
  a_r7_fail_forces_internal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_fail_o |-> (!clk_sel_o && !osts_o));

  // R8: flag holds until software clears it
  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_fail_if_o && !fail_clr_i) |=> osc_fail_if_o);

  // R5: entering failure raises the interrupt flag together
  a_r5_fail_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cm_fail_o) |-> osc_fail_if_o);
endmodule

bind fail_safe_clk_mon fscm_checker i_fscm_checker (
  .clk_i        (int_clk_i),
  .rst_ni       (rst_ni),
  .fail_clr_i   (fail_clr_i),
  .clk_sel_o    (clk_sel_o),
  .osts_o       (osts_o),
  .osc_fail_if_o(osc_fail_if_o),
  .cm_fail_o    (cm_fail_o)
);

// File: tb/test_fail_safe_clk_mon.sv
`timescale 1ns/1ps
module test_fail_safe_clk_mon;
  localparam int OST   = 1024;
  localparam int FAIL_WIN = 64;

  logic int_clk = 1'b0;
  logic pri_clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'd3;
  logic sleep = 1'b0;
  logic fail_clr = 1'b0;
  logic sys_clk, clk_sel, osts, fail_if, cm_fail;

  bit pri_run = 1'b0;
  int pri_half = 5;
  int pri_edges = 0;
  int sys_edges = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 int_clk = ~int_clk;

  initial begin
    forever begin
      if (pri_run) begin
        #(pri_half) pri_clk = ~pri_clk;
      end else begin
        pri_clk = 1'b0;
        #1;
      end
    end
  end

  always @(posedge pri_clk) pri_edges++;
  always @(posedge sys_clk) sys_edges++;

  fail_safe_clk_mon i_fail_safe_clk_mon (
    .int_clk_i    (int_clk),
    .pri_clk_i    (pri_clk),
    .rst_ni       (rst_n),
    .mode_i       (mode),
    .sleep_i      (sleep),
    .fail_clr_i   (fail_clr),
    .sys_clk_o    (sys_clk),
    .clk_sel_o    (clk_sel),
    .osts_o       (osts),
    .osc_fail_if_o(fail_if),
    .cm_fail_o    (cm_fail)
  );

  function automatic bit exp_crystal(input logic [2:0] m);
    return m >= 3'd2;
  endfunction

  function automatic int pick_half(input int idx);
    case (idx)
      0: return 3;
      1: return 5;
      2: return 7;
      default: return 11;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge int_clk);
  endtask

  task automatic wait_pri(input int n);
    while (pri_edges < n) @(negedge int_clk);
  endtask

  task automatic do_reset(input logic [2:0] m);
    @(negedge int_clk);
    rst_n = 1'b0;
    mode = m;
    cyc(3);
    // R1: reset values
    check(!clk_sel && !osts && !fail_if && !cm_fail, "R1 reset outputs",
          {clk_sel, osts, fail_if, cm_fail}, 0);
    rst_n = 1'b1;
    pri_edges = 0;
  endtask

  // stop primary clock and measure flag latency
  task automatic stop_and_check(input string tag);
    int lat;
    lat = 0;
    pri_run = 1'b0;
    while (!fail_if && lat < 200) begin
      cyc(1);
      lat++;
    end
    check(fail_if && cm_fail && lat <= FAIL_WIN, tag, lat, FAIL_WIN);
  endtask

  task automatic run_no_fail(input int n, input string tag);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      if (fail_if) seen++;
    end
    check(seen == 0, tag, seen, 0);
  endtask

  initial begin
    void'($urandom(32'd2718));

    // crystal mode with a crystal that does not start for a long time
    pri_run = 1'b0;
    do_reset(3'd3);
    run_no_fail(3000, "R3 no flag while crystal idle");
    check(!clk_sel && !osts, "R2 internal during idle start-up", {clk_sel, osts}, 0);
    pri_half = 5;
    pri_run = 1'b1;
    wait_pri(1000);
    cyc(1);
    check(!clk_sel && !osts, "R2 still internal before timer expiry", {clk_sel, osts}, 0);
    wait_pri(OST + 6);
    cyc(40);
    check(clk_sel && osts, "R2 switched after timer", {clk_sel, osts}, 3);
    run_no_fail(400, "R6 healthy primary");

    // failure and fallback
    stop_and_check("R5 stop latency");
    check(!clk_sel && !osts && cm_fail, "R7 fallback to internal", {clk_sel, osts, cm_fail}, 1);
    cyc(10);
    sys_edges = 0;
    cyc(16);
    check(sys_edges >= 15, "R10 sys clock from internal", sys_edges, 16);

    // sticky flag and clear
    cyc(100);
    check(fail_if && cm_fail, "R8 flag held", {fail_if, cm_fail}, 3);
    fail_clr = 1'b1;
    cyc(1);
    fail_clr = 1'b0;
    check(!fail_if && cm_fail, "R8 clear drops flag only", {fail_if, cm_fail}, 1);
    cyc(50);
    check(cm_fail && !clk_sel, "R7 failure state kept", {cm_fail, clk_sel}, 2);

    // sleep and wake restart the timer
    pri_run = 1'b1;
    sleep = 1'b1;
    cyc(20);
    check(!osts && !clk_sel && !cm_fail, "R9 sleep clears state", {osts, clk_sel, cm_fail}, 0);
    sleep = 1'b0;
    pri_edges = 0;
    cyc(50);
    check(!osts && !clk_sel, "R9 wake restarts timer", {osts, clk_sel}, 0);
    wait_pri(OST + 6);
    cyc(40);
    check(osts && clk_sel, "R9 R2 switch after wake", {osts, clk_sel}, 3);

    // external clock mode: immediate monitoring
    pri_half = 7;
    do_reset(3'd0);
    cyc(24);
    check(osts && clk_sel, "R4 ext mode immediate", {osts, clk_sel}, 3);
    check(pri_edges < OST, "R4 no timer wait", pri_edges, OST);
    run_no_fail(200, "R6 ext mode healthy");
    stop_and_check("R5 ext mode stop");

    // randomized scenarios
    for (int it = 0; it < 6; it++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 4));
      pri_half = pick_half($urandom_range(0, 3));
      pri_run = 1'b1;
      do_reset(m);
      if (exp_crystal(m)) begin
        wait_pri(500);
        cyc(1);
        check(!clk_sel && !osts, "R2 random crystal early", {clk_sel, osts}, 0);
        wait_pri(OST + 6);
        cyc(40);
        check(clk_sel && osts, "R2 random crystal switched", {clk_sel, osts}, 3);
      end else begin
        cyc(24);
        check(clk_sel && osts, "R4 random ext/rc", {clk_sel, osts}, 3);
      end
      run_no_fail($urandom_range(100, 300), "R6 random healthy");
      stop_and_check("R5 random stop");
      fail_clr = 1'b1;
      cyc(1);
      fail_clr = 1'b0;
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge int_clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule